// File: doc/BRIEF.md
# Multichannel PWM LED Controller with AXI4-Lite Register Access

This peripheral gives a processor brightness control over ten LED drive pins through a small AXI4-Lite slave. Each of ten 32-bit registers sets the duty of one pulse-width-modulated output. Four outputs serve single-colour LEDs. Six outputs serve two RGB LEDs: red, green and blue of the first LED, then red, green and blue of the second.

A single free-running 14-bit counter runs on the bus clock and serves all ten channels, so every channel has the same phase. Its top eight bits are the PWM phase. Each channel compares that phase with the low byte of its register and registers the result onto its pin. Software writes a duty at any time. The new value acts on the very next comparison and does not wait for the period to end.

Top module: `led_pwm_axil`

## Requirements
- R1: After the synchronous active-low reset, all ten registers read zero, every LED pin is low, and `s_bvalid` and `s_rvalid` are low.
- R2: Register n (0..9) sits at byte address 4*n. A read returns the full stored 32-bit word with response 2'b00 (OKAY), and every write response is 2'b00.
- R3: Bit i of `s_wstrb` enables the write of data bits [8i+7:8i]. Lanes whose strobe is clear keep their old contents.
- R4: A read at a word index of 10 or more, or at an address whose bits [1:0] are not zero, returns zero with an OKAY response. A write to such an address changes no register and no pin.
- R5: A write completes whether its address arrives before its data, after its data, or in the same cycle.
- R6: Once `s_bvalid` rises it stays high until accepted with `s_bready`. Once `s_rvalid` rises it stays high, with `s_rdata` unchanged, until accepted with `s_rready`.
- R7: Registers 0..3 drive `led_mono[0..3]`. Registers 4..9 drive `led_rgb[0..5]`, where bits 0,1,2 are red, green and blue of RGB LED one and bits 3,4,5 are red, green and blue of RGB LED two.
- R8: The pin value after the k-th rising edge since reset release (k >= 1) is (((k-1) >> 6) mod 256) < duty. The period is therefore 16384 clocks, and a channel with duty d is high for exactly 64*d clocks of any 16384-clock window.
- R9: Only register bits [7:0] set the duty. Bits [31:8] are stored and read back but do not affect the pin.
- R10: A duty of 0 keeps the pin constantly low. A changed duty reaches the pin at the first clock edge after the register update, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the PWM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 6 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| led_mono | output | 4 | Single-colour LED pins |
| led_rgb | output | 6 | RGB LED pins, R,G,B of LED one then LED two |

## Verification
The assertions assume that reset is held low for at least one clock edge before any traffic. They also assume the manager holds each VALID with stable address and data until it is accepted, as AXI requires. The response-hold checks depend on that stability. The bench drives every channel from tasks that keep VALID and payload steady until the matching ready is sampled high. It only releases reset at a falling edge. Random addresses cover the whole 6-bit space, including unused words and misaligned offsets, because the decode rules for those are part of the required behaviour and not a violated assumption.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
    localparam logic [1:0] AXI_RESP_OKAY = 2'b00;
    localparam int         LANE_W        = 8;
endpackage

// File: rtl/led_pwm_regbank.sv
module led_pwm_regbank
    import led_pwm_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int DUTY_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                s_awaddr,
    input  logic                             s_awvalid,
    output logic                             s_awready,
    input  logic [DATA_W-1:0]                s_wdata,
    input  logic [DATA_W/LANE_W-1:0]         s_wstrb,
    input  logic                             s_wvalid,
    output logic                             s_wready,
    output logic [1:0]                       s_bresp,
    output logic                             s_bvalid,
    input  logic                             s_bready,
    input  logic [ADDR_W-1:0]                s_araddr,
    input  logic                             s_arvalid,
    output logic                             s_arready,
    output logic [DATA_W-1:0]                s_rdata,
    output logic [1:0]                       s_rresp,
    output logic                             s_rvalid,
    input  logic                             s_rready,
    output logic [NUM_REGS-1:0][DUTY_W-1:0]  duty_o
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int LANES  = DATA_W / LANE_W;

    typedef struct packed {
        logic                             aw_have;
        logic [ADDR_W-1:0]                aw_addr;
        logic                             w_have;
        logic [DATA_W-1:0]                w_data;
        logic [LANES-1:0]                 w_strb;
        logic                             bvalid;
        logic                             rvalid;
        logic [DATA_W-1:0]                rdata;
        logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
    } bank_t;

    bank_t st_d, st_q;

    logic              aw_fire, w_fire, ar_fire, do_wr, rd_hit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, rd_word;
    logic [LANES-1:0]  wr_strb;

    always_comb begin
        st_d    = st_q;
        aw_fire = s_awvalid & ~st_q.aw_have;
        w_fire  = s_wvalid & ~st_q.w_have;
        ar_fire = s_arvalid & ~st_q.rvalid;
        wr_addr = st_q.aw_have ? st_q.aw_addr : s_awaddr;
        wr_data = st_q.w_have ? st_q.w_data : s_wdata;
        wr_strb = st_q.w_have ? st_q.w_strb : s_wstrb;
        do_wr   = (st_q.aw_have | aw_fire) & (st_q.w_have | w_fire) & ~st_q.bvalid;

        // capture each write channel independently
        if (aw_fire) begin
            st_d.aw_have = 1'b1;
            st_d.aw_addr = s_awaddr;
        end
        if (w_fire) begin
            st_d.w_have = 1'b1;
            st_d.w_data = s_wdata;
            st_d.w_strb = s_wstrb;
        end

        if (st_q.bvalid && s_bready) begin
            st_d.bvalid = 1'b0;
        end
        if (do_wr) begin
            st_d.aw_have = 1'b0;
            st_d.w_have  = 1'b0;
            st_d.bvalid  = 1'b1;
            for (int r = 0; r < NUM_REGS; r++) begin
                if (wr_addr[1:0] == 2'b00 && wr_addr[ADDR_W-1:2] == IDX_W'(r)) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (wr_strb[b]) begin
                            st_d.regs[r][LANE_W*b +: LANE_W] = wr_data[LANE_W*b +: LANE_W];
                        end
                    end
                end
            end
        end

        // read path
        rd_hit  = 1'b0;
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (s_araddr[1:0] == 2'b00 && s_araddr[ADDR_W-1:2] == IDX_W'(r)) begin
                rd_hit  = 1'b1;
                rd_word = st_q.regs[r];
            end
        end
        if (st_q.rvalid && s_rready) begin
            st_d.rvalid = 1'b0;
        end
        if (ar_fire) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_awready = ~st_q.aw_have;
    assign s_wready  = ~st_q.w_have;
    assign s_bvalid  = st_q.bvalid;
    assign s_bresp   = AXI_RESP_OKAY;
    assign s_arready = ~st_q.rvalid;
    assign s_rvalid  = st_q.rvalid;
    assign s_rdata   = st_q.rdata;
    assign s_rresp   = AXI_RESP_OKAY;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_duty
        assign duty_o[g] = st_q.regs[g][DUTY_W-1:0];
    end

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid) else $error("bvalid dropped"); // R6
    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))) else $error("rvalid dropped"); // R6
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && !rd_hit) |=> (s_rdata == '0)) else $error("unmapped read nonzero"); // R4
endmodule

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
    parameter int DUTY_W     = 8,
    parameter int PRESCALE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] phase_o
);
    localparam int CNT_W = DUTY_W + PRESCALE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tbase_t;

    tbase_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.cnt[CNT_W-1 -: DUTY_W];

    AST_COUNTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '1) |=> (st_q.cnt == '0)) else $error("counter did not wrap"); // R8
endmodule

// File: rtl/led_pwm_channel.sv
module led_pwm_channel #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] phase_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pin_o
);
    typedef struct packed {
        logic pin;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = (phase_i < duty_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |=> !pin_o) else $error("zero duty drove pin high"); // R10
endmodule

// File: rtl/led_pwm_axil.sv
module led_pwm_axil
    import led_pwm_pkg::*;
#(
    parameter int NUM_MONO   = 4,
    parameter int NUM_RGB    = 2,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int DUTY_W     = 8,
    parameter int PRESCALE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        s_awaddr,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [DATA_W-1:0]        s_wdata,
    input  logic [DATA_W/LANE_W-1:0] s_wstrb,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    output logic [1:0]               s_bresp,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic [ADDR_W-1:0]        s_araddr,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    output logic [DATA_W-1:0]        s_rdata,
    output logic [1:0]               s_rresp,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    output logic [NUM_MONO-1:0]      led_mono,
    output logic [3*NUM_RGB-1:0]     led_rgb
);
    localparam int NUM_CH = NUM_MONO + 3 * NUM_RGB;

    logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    logic [DUTY_W-1:0]             phase;
    logic [NUM_CH-1:0]             pins;

    led_pwm_regbank #(
        .NUM_REGS (NUM_CH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DUTY_W   (DUTY_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .duty_o    (duty)
    );

    led_pwm_timebase #(
        .DUTY_W     (DUTY_W),
        .PRESCALE_W (PRESCALE_W)
    ) u_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        led_pwm_channel #(
            .DUTY_W (DUTY_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .phase_i (phase),
            .duty_i  (duty[c]),
            .pin_o   (pins[c])
        );
    end

    assign led_mono = pins[NUM_MONO-1:0];
    assign led_rgb  = pins[NUM_CH-1:NUM_MONO];

    AST_RESET_PINS_LOW: assert property (@(posedge clk)
        !rst_n |=> (led_mono == '0 && led_rgb == '0)) else $error("pins high after reset"); // R1
endmodule

// File: tb/led_pwm_axil_tb.sv
module led_pwm_axil_tb;
    localparam int NCH = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [5:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [3:0]  led_mono;
    logic [5:0]  led_rgb;

    always #10 clk = ~clk;

    led_pwm_axil u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .led_mono(led_mono), .led_rgb(led_rgb)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] shadow [NCH];
    int          n_edges = 0;
    int          mism = 0;
    logic [9:0]  first_act, first_exp;
    int          hi_cnt [NCH];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_pin(input int k, input logic [7:0] d);
        if (k == 0) return 1'b0;
        return (8'(((k - 1) >> 6) & 255) < d);
    endfunction

    function automatic logic [9:0] exp_pins(input int k);
        logic [9:0] v;
        for (int c = 0; c < NCH; c++) v[c] = exp_pin(k, shadow[c][7:0]);
        return v;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] strb);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (strb[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        if (a[1:0] != 2'b00 || a[5:2] >= 4'(NCH)) return 32'h0;
        return shadow[a[5:2]];
    endfunction

    // pin monitor, away from the active edge
    always @(posedge clk) begin
        logic [9:0] act, exp;
        #5;
        if (rst_n) n_edges++;
        else       n_edges = 0;
        act = {led_rgb, led_mono};
        exp = exp_pins(n_edges);
        if (act != exp) begin
            if (mism == 0) begin first_act = act; first_exp = exp; end
            mism++;
        end
        for (int c = 0; c < NCH; c++) if (act[c]) hi_cnt[c]++;
    end

    task automatic clear_counts();
        mism = 0;
        for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    endtask

    task automatic axi_wr(input logic [5:0] addr, input logic [31:0] data, input logic [3:0] strb,
                          input int order, input int bdelay, input string req);
        bit aw_done = 0, w_done = 0, aw_now, w_now, held = 1;
        @(negedge clk);
        s_awaddr = addr; s_wdata = data; s_wstrb = strb;
        if (order != 2) s_awvalid = 1'b1;
        if (order != 1) s_wvalid  = 1'b1;
        while (!(aw_done && w_done)) begin
            aw_now = s_awvalid & s_awready;
            w_now  = s_wvalid & s_wready;
            @(negedge clk);
            if (aw_now) begin s_awvalid = 1'b0; aw_done = 1; end
            if (w_now)  begin s_wvalid  = 1'b0; w_done  = 1; end
            if (order == 1 && aw_done && !w_done) s_wvalid  = 1'b1;
            if (order == 2 && w_done && !aw_done) s_awvalid = 1'b1;
        end
        while (!s_bvalid) @(negedge clk);
        if (addr[1:0] == 2'b00 && addr[5:2] < 4'(NCH))
            shadow[addr[5:2]] = merge(shadow[addr[5:2]], data, strb);
        check(s_bresp == 2'b00, req, "write response", 32'(s_bresp), 32'h0);
        repeat (bdelay) begin
            @(negedge clk);
            if (!s_bvalid) held = 0;
        end
        if (bdelay > 0) check(held, "R6", "bvalid held under backpressure", 32'(held), 32'h1);
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic axi_rd(input logic [5:0] addr, input int rdelay, input string req);
        logic [31:0] d0, exp;
        bit held = 1;
        @(negedge clk);
        s_araddr = addr; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        d0  = s_rdata;
        exp = exp_read(addr);
        repeat (rdelay) begin
            @(negedge clk);
            if (!s_rvalid || s_rdata !== d0) held = 0;
        end
        if (rdelay > 0) check(held, "R6", "rvalid/rdata held under backpressure", 32'(held), 32'h1);
        check(d0 === exp, req, $sformatf("read addr 0x%02h", addr), d0, exp);
        check(s_rresp == 2'b00, req, "read response", 32'(s_rresp), 32'h0);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic period_check(input string tag);
        clear_counts();
        repeat (16384) @(negedge clk);
        check(mism == 0, "R8", {tag, " cycle-exact pin pattern"}, 32'(first_act), 32'(first_exp));
        for (int c = 0; c < NCH; c++) begin
            if (shadow[c][7:0] == 8'h00)
                check(hi_cnt[c] == 0, "R10", $sformatf("%s zero duty ch%0d high count", tag, c),
                      32'(hi_cnt[c]), 32'h0);
            else
                check(hi_cnt[c] == 64 * int'(shadow[c][7:0]), "R8",
                      $sformatf("%s ch%0d high count", tag, c),
                      32'(hi_cnt[c]), 32'(64 * int'(shadow[c][7:0])));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0x00000000 expected=0x00000001");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h1ED5);
        for (int c = 0; c < NCH; c++) shadow[c] = '0;
        repeat (4) @(negedge clk);
        check(led_mono == 4'h0 && led_rgb == 6'h0, "R1", "pins low in reset",
              32'({led_rgb, led_mono}), 32'h0);
        check(!s_bvalid && !s_rvalid, "R1", "no response valid in reset",
              32'({s_bvalid, s_rvalid}), 32'h0);
        rst_n = 1'b1;
        for (int r = 0; r < NCH; r++) axi_rd(6'(4 * r), 0, "R1");

        // write orderings and readback
        axi_wr(6'd8,  32'h1122_3344, 4'hF, 0, 0, "R5");
        axi_wr(6'd20, 32'hA5A5_0F0F, 4'hF, 1, 0, "R5");
        axi_wr(6'd36, 32'hDEAD_BEEF, 4'hF, 2, 0, "R5");
        axi_rd(6'd8,  0, "R5");
        axi_rd(6'd20, 0, "R5");
        axi_rd(6'd36, 0, "R2");

        // byte strobes
        axi_wr(6'd12, 32'hFFFF_FFFF, 4'hF, 0, 0, "R3");
        axi_wr(6'd12, 32'h00AA_0000, 4'b0100, 0, 0, "R3");
        axi_rd(6'd12, 0, "R3");
        axi_wr(6'd12, 32'h0000_0012, 4'b0001, 2, 0, "R3");
        axi_rd(6'd12, 0, "R3");

        // unmapped and misaligned
        axi_wr(6'd40, 32'h1234_5678, 4'hF, 0, 0, "R4");
        axi_wr(6'd60, 32'h8765_4321, 4'hF, 1, 0, "R4");
        axi_wr(6'd37, 32'h0000_0000, 4'hF, 0, 0, "R4");
        axi_rd(6'd40, 0, "R4");
        axi_rd(6'd60, 0, "R4");
        axi_rd(6'd38, 0, "R4");
        axi_rd(6'd36, 0, "R4");

        // backpressure
        axi_wr(6'd4, 32'h0000_00FF, 4'hF, 0, 5, "R6");
        axi_rd(6'd4, 6, "R6");

        // mapping and PWM: ch0 duty 0 with upper bits set, ch1 full scale
        axi_wr(6'd0, 32'hABCD_EF00, 4'hF, 0, 0, "R9");
        axi_rd(6'd0, 0, "R9");
        for (int c = 2; c < NCH; c++) axi_wr(6'(4 * c), {24'h5A5A00, 8'(c * 23 + 5)}, 4'hF, c % 3, 0, "R7");
        repeat (3000) @(negedge clk);
        check({led_rgb, led_mono} === exp_pins(n_edges), "R7", "pin-to-register mapping",
              32'({led_rgb, led_mono}), 32'(exp_pins(n_edges)));
        period_check("directed");

        // mid-period change takes effect on the next edge
        repeat (5000) @(negedge clk);
        clear_counts();
        axi_wr(6'd16, 32'h0000_00C0, 4'h1, 0, 0, "R10");
        axi_wr(6'd24, 32'h0000_0000, 4'hF, 0, 0, "R10");
        repeat (400) @(negedge clk);
        check(mism == 0, "R10", "duty change without period wait", 32'(first_act), 32'(first_exp));

        // constrained random traffic
        for (int i = 0; i < 60; i++) begin
            logic [5:0] a;
            a = 6'($urandom_range(0, 63));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            if ($urandom_range(0, 1) == 1)
                axi_wr(a, $urandom, 4'($urandom_range(0, 15)), $urandom_range(0, 2),
                       $urandom_range(0, 3), "R3");
            else
                axi_rd(a, $urandom_range(0, 3), "R2");
        end
        for (int r = 0; r < NCH; r++) axi_rd(6'(4 * r), 0, "R2");
        period_check("random");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule